// File: doc/BRIEF.md
# Seeded Generator Control Front-End

This block is the register front-end and command sequencer that sits in front of a deterministic random bit generator core. Software talks to it through a simple 32-bit word-access port. It holds the control settings, twelve external-seed words and twelve personalization words, and a 128-bit test seed that is built up one bit at a time. From these it presents a 384-bit seed and a 384-bit personalization value to the core, and it issues single-cycle reseed and generate strobes followed, for software-started commands, by a done pulse.

The seed fed downstream is picked by a fixed priority: the external seed words, then the test seed, then a free-running entropy input. Secret words are write-only; reading their addresses returns the status word instead. A hardware-version parameter selects which control bits are honoured and whether the extended control registers exist. Writing a 1 over a 0 in the reset register returns every register to its reset value.

Top module: `seedgen_ctrl`

## Requirements
- R1: After reset the control word (0x08) reads 0, control word 2 (0x0C) reads 0x210C, control word 3 (0x10) reads 0x26F09, the reset register (0xD0) reads 1, and reseed_o, generate_o and done_o are low.
- R2: A control write at 0x08 with start (bit 5) set and soft reset (bit 0) clear issues, one cycle after the write, generate_o when generate mode (bit 7) is set or reseed_o when it is clear; done_o pulses one cycle after that strobe and status bit 0 (address 0x04) then reads 1.
- R3: While the stored reset register bit 0 or the stored control soft-reset bit 0 is 1, a control write is stored but issues no strobe and no done pulse.
- R4: A control write with bit 0 set (when not already in reset) clears status bit 0 and issues no strobe.
- R5: seed_o carries the twelve external-seed words (0x40 + 4*i at bits 32*i) when control bit 3 is set; otherwise the test seed zero-extended in bits 127:0 when test mode (bit 6) is set; otherwise entropy_i.
- R6: pers_o carries the twelve personalization words (0x80 + 4*i at bits 32*i) unless personalization disable (bit 10) is set, in which case it is all zeros.
- R7: A write to 0x14 while test mode (bit 6) and source enable (bit 2) are set and the block is not in reset shifts wdata bit 0 into the test seed LSB, issues reseed_o one cycle later and generate_o one cycle after that, and no done pulse; otherwise the test seed is unchanged and no strobe is issued.
- R8: A read of any address from 0x40 to 0xAC returns the status word, never the stored secret.
- R9: With HW_VER at or above 0x0200, bits 4 and 1 of a control write are stored as 0.
- R10: With HW_VER below 0x0200, bits 10 and 9 of a control write are stored as 0 and writes to 0x0C, 0x10 and 0x14 are ignored.
- R11: A write of 1 to reset register bit 0 while it holds 0 restores every register to its reset value and clears the seed words, personalization words and test seed.
- R12: Read data appears on bus_rdata one cycle after bus_rd is sampled; unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_rd | input | 1 | Read strobe, sampled on the rising edge |
| bus_addr | input | 8 | Byte address of the word accessed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| entropy_i | input | 384 | True entropy input used when no other seed source is chosen |
| seed_o | output | 384 | Selected seed for the generator core |
| pers_o | output | 384 | Personalization value, zero when disabled |
| reseed_o | output | 1 | Single-cycle reseed command |
| generate_o | output | 1 | Single-cycle generate command |
| done_o | output | 1 | Single-cycle completion pulse for started commands |

## Verification
A strobe from a control write is due on the first clock edge after the write edge, the done pulse and the second strobe of a test-bit load one edge later, and read data one edge after the read is sampled; seed_o and pers_o follow stored state and are valid right after the write edge. The bench drives every access on the falling edge and samples results on the following falling edges, counting exactly one edge for a strobe and two for done or the chained generate, and checks the silent cycles of ignored commands on both edges. A second instance built with a pre-0x0200 version runs the same register vectors so the two masking variants are compared against separate expected values.

// File: rtl/seedgen_pkg.sv
package seedgen_pkg;

    localparam int unsigned WORD_W       = 32;
    localparam int unsigned SECRET_WORDS = 12;
    localparam int unsigned TSEED_W      = 128;
    localparam int unsigned SEED_W       = WORD_W * SECRET_WORDS;
    localparam int unsigned CTRL_W       = 11;
    localparam int unsigned IDX_W        = $clog2(SECRET_WORDS);

    localparam logic [7:0] A_STATUS    = 8'h04;
    localparam logic [7:0] A_CTRL      = 8'h08;
    localparam logic [7:0] A_CTRL2     = 8'h0C;
    localparam logic [7:0] A_CTRL3     = 8'h10;
    localparam logic [7:0] A_TBIT      = 8'h14;
    localparam logic [7:0] A_SEED_LO   = 8'h40;
    localparam logic [7:0] A_SECRET_HI = 8'hAC;
    localparam logic [7:0] A_RSTREG    = 8'hD0;

    // control word bit positions
    localparam int unsigned CB_SRST     = 0;
    localparam int unsigned CB_HTEN     = 1;
    localparam int unsigned CB_SRCEN    = 2;
    localparam int unsigned CB_EXTSEED  = 3;
    localparam int unsigned CB_AUTOTEST = 4;
    localparam int unsigned CB_START    = 5;
    localparam int unsigned CB_TEST     = 6;
    localparam int unsigned CB_GENMODE  = 7;
    localparam int unsigned CB_SINGLE   = 9;
    localparam int unsigned CB_PERSOFF  = 10;

    localparam logic [WORD_W-1:0] CTRL2_RST = 32'h0000_210C;
    localparam logic [WORD_W-1:0] CTRL3_RST = 32'h0002_6F09;
    localparam logic [15:0]       VER_NEW   = 16'h0200;

    typedef enum logic [2:0] {
        REG_NONE, REG_CTRL, REG_CTRL2, REG_CTRL3,
        REG_TBIT, REG_SEED, REG_PERS, REG_RST
    } reg_sel_e;

    typedef struct packed {
        logic [CTRL_W-1:0] ctrl;
        logic [WORD_W-1:0] ctrl2;
        logic [WORD_W-1:0] ctrl3;
        logic              rstreg;
        logic [WORD_W-1:0] rdata;
    } front_t;

    typedef struct packed {
        logic reseed;
        logic gen;
        logic done;
        logic pend_gen;
        logic pend_done;
        logic sticky;
    } seq_t;

    function automatic reg_sel_e decode_addr(input logic [7:0] a);
        reg_sel_e s;
        s = REG_NONE;
        if (a[1:0] == 2'b00) begin
            if (a[7:6] == 2'b01 && a[5:2] < 4'(SECRET_WORDS)) begin
                s = REG_SEED;
            end else if (a[7:6] == 2'b10 && a[5:2] < 4'(SECRET_WORDS)) begin
                s = REG_PERS;
            end else begin
                case (a)
                    A_CTRL:   s = REG_CTRL;
                    A_CTRL2:  s = REG_CTRL2;
                    A_CTRL3:  s = REG_CTRL3;
                    A_TBIT:   s = REG_TBIT;
                    A_RSTREG: s = REG_RST;
                    default:  s = REG_NONE;
                endcase
            end
        end
        return s;
    endfunction

endpackage

// File: rtl/seedgen_wmask.sv
module seedgen_wmask
    import seedgen_pkg::*;
#(
    parameter logic [15:0] HW_VER = 16'h0200
) (
    input  reg_sel_e          sel,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] wdata_o,
    output logic              drop_o
);

    generate
        if (HW_VER < VER_NEW) begin : g_legacy
            always_comb begin
                wdata_o = wdata;
                drop_o  = 1'b0;
                if (sel == REG_CTRL) begin
                    wdata_o[CB_PERSOFF] = 1'b0;
                    wdata_o[CB_SINGLE]  = 1'b0;
                end
                if (sel inside {REG_CTRL2, REG_CTRL3, REG_TBIT}) begin
                    drop_o = 1'b1;
                end
            end
        end else begin : g_current
            always_comb begin
                wdata_o = wdata;
                drop_o  = 1'b0;
                if (sel == REG_CTRL) begin
                    wdata_o[CB_AUTOTEST] = 1'b0;
                    wdata_o[CB_HTEN]     = 1'b0;
                end
            end
        end
    endgenerate

endmodule

// File: rtl/seedgen_word_bank.sv
module seedgen_word_bank
    import seedgen_pkg::*;
#(
    parameter int unsigned NWORDS = SECRET_WORDS,
    parameter int unsigned W      = WORD_W,
    parameter int unsigned AW     = $clog2(NWORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              we,
    input  logic [AW-1:0]     idx,
    input  logic [W-1:0]      wdata,
    output logic [NWORDS*W-1:0] flat_o
);

    generate
        for (genvar i = 0; i < NWORDS; i++) begin : g_word
            logic [W-1:0] word_d, word_q;

            always_comb begin
                word_d = word_q;
                if (clr) begin
                    word_d = '0;
                end else if (we && idx == AW'(i)) begin
                    word_d = wdata;
                end
            end

            always_ff @(posedge clk) begin
                if (!rst_n) word_q <= '0;
                else        word_q <= word_d;
            end

            assign flat_o[i*W +: W] = word_q;
        end
    endgenerate

endmodule

// File: rtl/seedgen_tseed.sv
module seedgen_tseed
    import seedgen_pkg::*;
#(
    parameter int unsigned W = TSEED_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         shift,
    input  logic         bit_in,
    output logic [W-1:0] q_o
);

    logic [W-1:0] sr_d, sr_q;

    always_comb begin
        sr_d = sr_q;
        if (clr) begin
            sr_d = '0;
        end else if (shift) begin
            sr_d = {sr_q[W-2:0], bit_in};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sr_q <= '0;
        else        sr_q <= sr_d;
    end

    assign q_o = sr_q;

endmodule

// File: rtl/seedgen_seq.sv
module seedgen_seq
    import seedgen_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic go_reseed,
    input  logic go_gen,
    input  logic go_tload,
    input  logic flush,
    output logic reseed_o,
    output logic gen_o,
    output logic done_o,
    output logic sticky_o
);

    seq_t d, q;

    always_comb begin
        d           = '0;
        d.sticky    = q.sticky;
        if (q.pend_gen) begin
            d.gen = 1'b1;
        end
        if (q.pend_done) begin
            d.done   = 1'b1;
            d.sticky = 1'b1;
        end
        if (go_reseed) begin
            d.reseed    = 1'b1;
            d.pend_done = 1'b1;
        end
        if (go_gen) begin
            d.gen       = 1'b1;
            d.pend_done = 1'b1;
        end
        if (go_tload) begin
            d.reseed   = 1'b1;
            d.pend_gen = 1'b1;
        end
        // a soft or full reset drops completion state; a chained generate still fires
        if (flush) begin
            d.pend_done = 1'b0;
            d.done      = 1'b0;
            d.sticky    = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign reseed_o = q.reseed;
    assign gen_o    = q.gen;
    assign done_o   = q.done;
    assign sticky_o = q.sticky;

endmodule

// File: rtl/seedgen_ctrl.sv
module seedgen_ctrl
    import seedgen_pkg::*;
#(
    parameter logic [15:0] HW_VER = 16'h0200
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [7:0]        bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    input  logic [SEED_W-1:0] entropy_i,
    output logic [SEED_W-1:0] seed_o,
    output logic [SEED_W-1:0] pers_o,
    output logic              reseed_o,
    output logic              generate_o,
    output logic              done_o
);

    front_t d, q;

    reg_sel_e          sel;
    logic [WORD_W-1:0] wd;
    logic              drop;
    logic              wr_ok, in_reset, full_rst, ctrl_wr, ctrl_act;
    logic              soft_rst, start_acc, tload_acc;
    logic              seed_we, pers_we;
    logic              done_sticky;
    logic [WORD_W-1:0] status_w;
    logic [SEED_W-1:0] seed_words, pers_words;
    logic [TSEED_W-1:0] tseed;

    assign sel = decode_addr(bus_addr);

    seedgen_wmask #(.HW_VER(HW_VER)) u_wmask (
        .sel     (sel),
        .wdata   (bus_wdata),
        .wdata_o (wd),
        .drop_o  (drop)
    );

    assign wr_ok     = bus_wr && !drop;
    assign in_reset  = q.rstreg || q.ctrl[CB_SRST];
    assign full_rst  = wr_ok && (sel == REG_RST) && !q.rstreg && wd[0];
    assign ctrl_wr   = wr_ok && (sel == REG_CTRL);
    assign ctrl_act  = ctrl_wr && !in_reset;
    assign soft_rst  = ctrl_act && wd[CB_SRST];
    assign start_acc = ctrl_act && !wd[CB_SRST] && wd[CB_START];
    assign tload_acc = wr_ok && (sel == REG_TBIT) && !in_reset
                       && q.ctrl[CB_TEST] && q.ctrl[CB_SRCEN];
    assign seed_we   = wr_ok && (sel == REG_SEED);
    assign pers_we   = wr_ok && (sel == REG_PERS);
    assign status_w  = {{(WORD_W-1){1'b0}}, done_sticky};

    seedgen_word_bank u_seed_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (full_rst),
        .we     (seed_we),
        .idx    (bus_addr[IDX_W+1:2]),
        .wdata  (wd),
        .flat_o (seed_words)
    );

    seedgen_word_bank u_pers_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (full_rst),
        .we     (pers_we),
        .idx    (bus_addr[IDX_W+1:2]),
        .wdata  (wd),
        .flat_o (pers_words)
    );

    seedgen_tseed u_tseed (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (full_rst),
        .shift  (tload_acc),
        .bit_in (wd[0]),
        .q_o    (tseed)
    );

    seedgen_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .go_reseed (start_acc && !wd[CB_GENMODE]),
        .go_gen    (start_acc && wd[CB_GENMODE]),
        .go_tload  (tload_acc),
        .flush     (soft_rst || full_rst),
        .reseed_o  (reseed_o),
        .gen_o     (generate_o),
        .done_o    (done_o),
        .sticky_o  (done_sticky)
    );

    always_comb begin
        d = q;
        if (ctrl_wr) begin
            d.ctrl = wd[CTRL_W-1:0];
        end
        if (wr_ok && sel == REG_CTRL2) begin
            d.ctrl2 = wd;
        end
        if (wr_ok && sel == REG_CTRL3) begin
            d.ctrl3 = wd;
        end
        if (wr_ok && sel == REG_RST) begin
            d.rstreg = wd[0];
        end
        if (full_rst) begin
            d.ctrl  = '0;
            d.ctrl2 = CTRL2_RST;
            d.ctrl3 = CTRL3_RST;
        end
        if (bus_rd) begin
            if (bus_addr >= A_SEED_LO && bus_addr <= A_SECRET_HI) begin
                d.rdata = status_w;
            end else begin
                case (bus_addr)
                    A_STATUS: d.rdata = status_w;
                    A_CTRL:   d.rdata = {{(WORD_W-CTRL_W){1'b0}}, q.ctrl};
                    A_CTRL2:  d.rdata = q.ctrl2;
                    A_CTRL3:  d.rdata = q.ctrl3;
                    A_RSTREG: d.rdata = {{(WORD_W-1){1'b0}}, q.rstreg};
                    default:  d.rdata = '0;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.ctrl   <= '0;
            q.ctrl2  <= CTRL2_RST;
            q.ctrl3  <= CTRL3_RST;
            q.rstreg <= 1'b1;
            q.rdata  <= '0;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        if (q.ctrl[CB_EXTSEED]) begin
            seed_o = seed_words;
        end else if (q.ctrl[CB_TEST]) begin
            seed_o = SEED_W'(tseed);
        end else begin
            seed_o = entropy_i;
        end
    end

    assign pers_o    = q.ctrl[CB_PERSOFF] ? '0 : pers_words;
    assign bus_rdata = q.rdata;

endmodule

// File: rtl/seedgen_ctrl_chk.sv
module seedgen_ctrl_chk
    import seedgen_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              bus_rd,
    input logic [7:0]        bus_addr,
    input logic [WORD_W-1:0] bus_rdata,
    input logic [WORD_W-1:0] status_w,
    input logic              start_acc,
    input logic              tload_acc,
    input logic              reseed_o,
    input logic              generate_o,
    input logic              done_o
);

    assert_strobe_after_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        start_acc |=> (reseed_o || generate_o))
        else $error("start accepted without a strobe");

    assert_done_follows_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(reseed_o || generate_o))
        else $error("done without a preceding strobe");

    assert_tload_reseed_R7: assert property (@(posedge clk) disable iff (!rst_n)
        tload_acc |=> reseed_o)
        else $error("test bit load without reseed");

    assert_tload_generate_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(tload_acc, 2) |-> generate_o)
        else $error("test bit load without chained generate");

    assert_secret_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr >= A_SEED_LO && bus_addr <= A_SECRET_HI)
            |=> (bus_rdata == $past(status_w)))
        else $error("secret word read returned something other than status");

endmodule

bind seedgen_ctrl seedgen_ctrl_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_rd     (bus_rd),
    .bus_addr   (bus_addr),
    .bus_rdata  (bus_rdata),
    .status_w   (status_w),
    .start_acc  (start_acc),
    .tload_acc  (tload_acc),
    .reseed_o   (reseed_o),
    .generate_o (generate_o),
    .done_o     (done_o)
);

// File: tb/seedgen_ctrl_tb_top.sv
`timescale 1ns/1ps
module seedgen_ctrl_tb_top;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bus_wr = 1'b0;
    logic         bus_rd = 1'b0;
    logic [7:0]   bus_addr = 8'h00;
    logic [31:0]  bus_wdata = 32'h0;
    logic [383:0] entropy = '0;
    logic [31:0]  rdata_n, rdata_o;
    logic [383:0] seed_n, pers_n, seed_o_old, pers_o_old;
    logic         rs_n, gn_n, dn_n, rs_o, gn_o, dn_o;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    seedgen_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata_n),
        .entropy_i(entropy), .seed_o(seed_n), .pers_o(pers_n),
        .reseed_o(rs_n), .generate_o(gn_n), .done_o(dn_n)
    );

    seedgen_ctrl #(.HW_VER(16'h0100)) dut_old (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata_o),
        .entropy_i(entropy), .seed_o(seed_o_old), .pers_o(pers_o_old),
        .reseed_o(rs_o), .generate_o(gn_o), .done_o(dn_o)
    );

    // write addr, write data, read addr, expected (current version), expected (legacy)
    localparam logic [111:0] VEC [6] = '{
        {8'h08, 32'h0000_0612, 8'h08, 32'h0000_0600, 32'h0000_0012},
        {8'h0C, 32'h0000_ABCD, 8'h0C, 32'h0000_ABCD, 32'h0000_210C},
        {8'h10, 32'h0000_1357, 8'h10, 32'h0000_1357, 32'h0002_6F09},
        {8'h40, 32'hDEAD_BEEF, 8'h40, 32'h0000_0000, 32'h0000_0000},
        {8'h84, 32'h1111_2222, 8'hAC, 32'h0000_0000, 32'h0000_0000},
        {8'h08, 32'h0000_0000, 8'h08, 32'h0000_0000, 32'h0000_0000}
    };

    task automatic chk(input string req, input logic [383:0] act, input logic [383:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] dv);
        @(negedge clk);
        bus_addr = a; bus_wdata = dv; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 12; i++) entropy[i*32 +: 32] = 32'h1000_0000 + i * 32'h0101;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 reseed low", rs_n, 0);
        chk("R1 generate low", gn_n, 0);
        chk("R1 done low", dn_n, 0);
        rd(8'h0C); chk("R1 ctrl2 reset", rdata_n, 32'h210C);
        rd(8'h10); chk("R1 ctrl3 reset", rdata_n, 32'h26F09);
        rd(8'hD0); chk("R1 reset register", rdata_n, 1);
        rd(8'h08); chk("R1 ctrl reset", rdata_n, 0);
        rd(8'h20); chk("R12 unmapped reads 0", rdata_n, 0);

        wr(8'hD0, 32'h0);

        // R8 R9 R10 register vectors, both versions
        for (int i = 0; i < 6; i++) begin
            wr(VEC[i][111:104], VEC[i][103:72]);
            rd(VEC[i][71:64]);
            chk("R8 R9 vector current", rdata_n, VEC[i][63:32]);
            chk("R10 vector legacy", rdata_o, VEC[i][31:0]);
        end

        // R6 personalization
        chk("R6 pers word 1", pers_n[63:32], 32'h1111_2222);
        wr(8'h08, 32'h400);
        chk("R6 pers disabled", pers_n, 0);

        // R5 seed selection
        wr(8'h6C, 32'hCAFE_F00D);
        wr(8'h08, 32'h008);
        chk("R5 ext seed word 0", seed_n[31:0], 32'hDEAD_BEEF);
        chk("R5 ext seed word 11", seed_n[383:352], 32'hCAFE_F00D);
        wr(8'h08, 32'h000);
        chk("R5 entropy selected", seed_n, entropy);
        wr(8'h08, 32'h044);
        chk("R5 test seed empty", seed_n, 0);

        // R7 test bit loading
        wr(8'h14, 32'h1);
        chk("R7 reseed after load", rs_n, 1);
        chk("R7 no generate yet", gn_n, 0);
        @(negedge clk);
        chk("R7 chained generate", gn_n, 1);
        chk("R7 reseed single cycle", rs_n, 0);
        chk("R7 no done", dn_n, 0);
        wr(8'h14, 32'h0);
        wr(8'h14, 32'h1);
        chk("R7 shifted value", seed_n, 384'd5);
        wr(8'h08, 32'h04C);
        chk("R5 ext beats test", seed_n[31:0], 32'hDEAD_BEEF);
        wr(8'h08, 32'h040);
        wr(8'h14, 32'h1);
        chk("R7 no reseed without source enable", rs_n, 0);
        chk("R7 seed unchanged", seed_n, 384'd5);
        @(negedge clk);
        chk("R7 no generate without source enable", gn_n, 0);

        // R2 started commands
        wr(8'h08, 32'h020);
        chk("R2 reseed strobe", rs_n, 1);
        chk("R2 no generate", gn_n, 0);
        @(negedge clk);
        chk("R2 done after reseed", dn_n, 1);
        chk("R2 reseed single cycle", rs_n, 0);
        rd(8'h04); chk("R2 status done", rdata_n, 1);
        wr(8'h08, 32'h0A0);
        chk("R2 generate strobe", gn_n, 1);
        chk("R2 no reseed", rs_n, 0);
        @(negedge clk);
        chk("R2 done after generate", dn_n, 1);

        // R4 soft reset
        wr(8'h08, 32'h001);
        chk("R4 no strobe on soft reset", rs_n | gn_n, 0);
        rd(8'h04); chk("R4 status cleared", rdata_n, 0);

        // R3 commands blocked while soft reset is stored
        wr(8'h08, 32'h020);
        chk("R3 blocked reseed", rs_n, 0);
        @(negedge clk);
        chk("R3 blocked done", dn_n, 0);
        wr(8'h08, 32'h020);
        chk("R3 accepted once reset released", rs_n, 1);

        // R11 full reset via reset register
        wr(8'h0C, 32'h55);
        wr(8'hD0, 32'h1);
        rd(8'h0C); chk("R11 ctrl2 restored", rdata_n, 32'h210C);
        rd(8'h08); chk("R11 ctrl cleared", rdata_n, 0);
        wr(8'h08, 32'h028);
        chk("R3 blocked by reset register", rs_n, 0);
        chk("R11 seed words cleared", seed_n, 0);
        @(negedge clk);
        chk("R3 no done under reset register", dn_n, 0);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule